// File: doc/BRIEF.md
# Preemptive Shared-Bus Arbiter with Bus Lock

This block connects several Wishbone-style masters to one shared slave port. Each master presents a bus request (CYC), a transfer strobe (STB), a lock flag, a write enable, an address and write data. The arbiter picks one owner by fixed priority, with master 0 ranked highest, and routes that owner's signals to the slave. Cycle terminations from the slave (acknowledge, error, retry) go back only to the granted master, and only while that master has both CYC and STB high.

Ownership is not permanent. A master that keeps CYC high but has no lock can lose the bus to a higher-priority requester. This can only happen on an edge where no transfer is waiting for its termination. A master that holds CYC and LOCK together keeps the bus against every other master. The lock ends as soon as the owner drops either signal. A LOCK flag from a master whose CYC is low means nothing. When nobody requests, the last grant stays registered and the slave strobes stay low.

Top module: `shbus_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant. While the grant is clear, `m_gnt` is all zero, `s_cyc` and `s_stb` are low, and no master receives a termination, even if its CYC, its STB and a slave termination are all high.
- R2: From an idle state, the requester with the lowest index is granted at the first clock edge after its CYC rises. `m_gnt` is one-hot, and bit i set means master i owns the bus.
- R3: `s_adr`, `s_we` and `s_wdat` carry the granted master's fields. `s_cyc` equals the owner's CYC. `s_stb` is the owner's CYC AND STB, so `s_stb` is never high while `s_cyc` is low. `m_rdat` carries `s_rdat` to every master.
- R4: An owner that holds CYC high with STB low keeps the bus against lower-priority requesters, and `s_stb` stays low during those cycles.
- R5: When the owner has CYC high, LOCK low and no transfer pending, a higher-priority master that raises CYC is granted at the next edge.
- R6: While the owner holds both CYC and LOCK high, the grant does not change, whatever any other master requests.
- R7: The lock ends on the edge after the owner drops LOCK or CYC. LOCK from a master whose CYC is low is ignored, whether or not that master holds the grant.
- R8: While `s_stb` is high and no termination is present, the grant is not moved. The edge at which a termination arrives may re-arbitrate.
- R9: `m_ack[i]`, `m_err[i]` and `m_rty[i]` follow `s_ack`, `s_err` and `s_rty` in the same cycle, only when master i is granted and has CYC and STB high. For all other masters they are zero.
- R10: When no master requests, `m_gnt` keeps the last owner and `s_cyc` and `s_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | N_MASTERS | Per-master bus request |
| m_stb | input | N_MASTERS | Per-master transfer strobe |
| m_lock | input | N_MASTERS | Per-master lock flag |
| m_we | input | N_MASTERS | Per-master write enable |
| m_adr | input | N_MASTERS*AW | Packed addresses, master i at bits [i*AW +: AW] |
| m_wdat | input | N_MASTERS*DW | Packed write data, master i at bits [i*DW +: DW] |
| m_rdat | output | DW | Read data returned to all masters |
| m_ack | output | N_MASTERS | Per-master acknowledge |
| m_err | output | N_MASTERS | Per-master error |
| m_rty | output | N_MASTERS | Per-master retry |
| m_gnt | output | N_MASTERS | One-hot current owner |
| s_cyc | output | 1 | Slave bus request |
| s_stb | output | 1 | Slave transfer strobe |
| s_we | output | 1 | Slave write enable |
| s_adr | output | AW | Slave address |
| s_wdat | output | DW | Slave write data |
| s_rdat | input | DW | Slave read data |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error |
| s_rty | input | 1 | Slave retry |

## Verification
The tests raise requests on several masters at once, to check that the lowest index wins. They also raise higher-priority requests while the owner is idle, in the middle of a strobe, and while it is locked, to tell apart a legal preemption from one blocked by a pending transfer or by a lock. The lock is released in two ways, by dropping LOCK and by dropping CYC. A stray LOCK is left on a master whose CYC is low, to show that it is ignored. Every slave termination is asserted while a non-granted master has CYC and STB high, to show that no termination leaks to a master that does not own the bus.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    // Decision taken by the grant controller on a clock edge
    typedef enum logic [1:0] {
        ARB_KEEP_XFER = 2'd0,  // strobe pending without termination
        ARB_KEEP_LOCK = 2'd1,  // owner holds CYC and LOCK
        ARB_REPICK    = 2'd2,  // free to move to best requester
        ARB_IDLE      = 2'd3   // nobody requests, keep last owner
    } arb_dec_e;

endpackage

// File: rtl/shbus_prio_pick.sv
module shbus_prio_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Lowest index wins; scan from the top so the lowest match lands last
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/shbus_grant_ctrl.sv
module shbus_grant_ctrl
    import shbus_pkg::*;
#(
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] pick_idx,
    input  logic          pick_any,
    input  logic          own_cyc,
    input  logic          own_stb,
    input  logic          own_lock,
    input  logic          term,
    output logic [IW-1:0] owner,
    output logic          valid
);

    typedef struct packed {
        logic [IW-1:0] owner;
        logic          valid;
    } gstate_t;

    gstate_t  st_d, st_q;
    arb_dec_e dec;

    always_comb begin
        st_d = st_q;
        if (own_stb && !term)        dec = ARB_KEEP_XFER;
        else if (own_cyc && own_lock) dec = ARB_KEEP_LOCK;
        else if (pick_any)            dec = ARB_REPICK;
        else                          dec = ARB_IDLE;

        case (dec)
            ARB_REPICK: begin
                st_d.owner = pick_idx;
                st_d.valid = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner = st_q.owner;
    assign valid = st_q.valid;

endmodule

// File: rtl/shbus_route.sv
module shbus_route #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32,
    parameter int unsigned IW = 2
) (
    input  logic [IW-1:0]   owner,
    input  logic            valid,
    input  logic [N-1:0]    m_cyc,
    input  logic [N-1:0]    m_stb,
    input  logic [N-1:0]    m_lock,
    input  logic [N-1:0]    m_we,
    input  logic [N*AW-1:0] m_adr,
    input  logic [N*DW-1:0] m_wdat,
    input  logic            s_ack,
    input  logic            s_err,
    input  logic            s_rty,
    output logic            s_cyc,
    output logic            s_stb,
    output logic            s_we,
    output logic [AW-1:0]   s_adr,
    output logic [DW-1:0]   s_wdat,
    output logic            own_lock,
    output logic [N-1:0]    gnt,
    output logic [N-1:0]    m_ack,
    output logic [N-1:0]    m_err,
    output logic [N-1:0]    m_rty
);

    logic [AW-1:0] adr_a  [N];
    logic [DW-1:0] wdat_a [N];

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign adr_a[i]  = m_adr[i*AW +: AW];
        assign wdat_a[i] = m_wdat[i*DW +: DW];
        assign gnt[i]    = valid && (owner == IW'(i));
        // termination only reaches the owner with CYC and STB both high
        assign m_ack[i]  = gnt[i] & m_cyc[i] & m_stb[i] & s_ack;
        assign m_err[i]  = gnt[i] & m_cyc[i] & m_stb[i] & s_err;
        assign m_rty[i]  = gnt[i] & m_cyc[i] & m_stb[i] & s_rty;
    end

    assign s_cyc    = valid & m_cyc[owner];
    assign s_stb    = s_cyc & m_stb[owner];
    assign own_lock = valid & m_lock[owner];
    assign s_we     = m_we[owner];
    assign s_adr    = adr_a[owner];
    assign s_wdat   = wdat_a[owner];

endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter #(
    parameter int unsigned N_MASTERS = 4,
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_MASTERS-1:0]   m_cyc,
    input  logic [N_MASTERS-1:0]   m_stb,
    input  logic [N_MASTERS-1:0]   m_lock,
    input  logic [N_MASTERS-1:0]   m_we,
    input  logic [N_MASTERS*AW-1:0] m_adr,
    input  logic [N_MASTERS*DW-1:0] m_wdat,
    output logic [DW-1:0]          m_rdat,
    output logic [N_MASTERS-1:0]   m_ack,
    output logic [N_MASTERS-1:0]   m_err,
    output logic [N_MASTERS-1:0]   m_rty,
    output logic [N_MASTERS-1:0]   m_gnt,
    output logic                   s_cyc,
    output logic                   s_stb,
    output logic                   s_we,
    output logic [AW-1:0]          s_adr,
    output logic [DW-1:0]          s_wdat,
    input  logic [DW-1:0]          s_rdat,
    input  logic                   s_ack,
    input  logic                   s_err,
    input  logic                   s_rty
);

    localparam int unsigned IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic [IW-1:0] owner;
    logic          valid;
    logic          own_lock;
    logic          term;

    assign term   = s_ack | s_err | s_rty;
    assign m_rdat = s_rdat;

    shbus_prio_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
        .req (m_cyc),
        .idx (pick_idx),
        .any (pick_any)
    );

    shbus_grant_ctrl #(.IW(IW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pick_idx (pick_idx),
        .pick_any (pick_any),
        .own_cyc  (s_cyc),
        .own_stb  (s_stb),
        .own_lock (own_lock),
        .term     (term),
        .owner    (owner),
        .valid    (valid)
    );

    shbus_route #(.N(N_MASTERS), .AW(AW), .DW(DW), .IW(IW)) u_route (
        .owner    (owner),
        .valid    (valid),
        .m_cyc    (m_cyc),
        .m_stb    (m_stb),
        .m_lock   (m_lock),
        .m_we     (m_we),
        .m_adr    (m_adr),
        .m_wdat   (m_wdat),
        .s_ack    (s_ack),
        .s_err    (s_err),
        .s_rty    (s_rty),
        .s_cyc    (s_cyc),
        .s_stb    (s_stb),
        .s_we     (s_we),
        .s_adr    (s_adr),
        .s_wdat   (s_wdat),
        .own_lock (own_lock),
        .gnt      (m_gnt),
        .m_ack    (m_ack),
        .m_err    (m_err),
        .m_rty    (m_rty)
    );

endmodule

// File: rtl/shbus_arbiter_chk.sv
module shbus_arbiter_chk #(
    parameter int unsigned N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] m_cyc,
    input logic [N_MASTERS-1:0] m_stb,
    input logic [N_MASTERS-1:0] m_lock,
    input logic [N_MASTERS-1:0] m_gnt,
    input logic [N_MASTERS-1:0] m_ack,
    input logic [N_MASTERS-1:0] m_err,
    input logic [N_MASTERS-1:0] m_rty,
    input logic                 s_cyc,
    input logic                 s_stb,
    input logic                 s_ack,
    input logic                 s_err,
    input logic                 s_rty
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (m_gnt == '0) && !s_cyc && !s_stb);

    a_r2_one_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_gnt));

    a_r3_stb_needs_cyc: assert property (@(posedge clk) disable iff (rst)
        !s_cyc |-> !s_stb);

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (|(m_gnt & m_cyc & m_lock)) |=> $stable(m_gnt));

    a_r8_no_split: assert property (@(posedge clk) disable iff (rst)
        (s_stb && !(s_ack || s_err || s_rty)) |=> $stable(m_gnt));

    a_r9_term_gated: assert property (@(posedge clk) disable iff (rst)
        ((m_ack | m_err | m_rty) & ~(m_gnt & m_cyc & m_stb)) == '0);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (m_cyc == '0) |-> (!s_cyc && !s_stb));

endmodule

bind shbus_arbiter shbus_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .m_cyc  (m_cyc),
    .m_stb  (m_stb),
    .m_lock (m_lock),
    .m_gnt  (m_gnt),
    .m_ack  (m_ack),
    .m_err  (m_err),
    .m_rty  (m_rty),
    .s_cyc  (s_cyc),
    .s_stb  (s_stb),
    .s_ack  (s_ack),
    .s_err  (s_err),
    .s_rty  (s_rty)
);

// File: tb/shbus_arbiter_bench.sv
`timescale 1ns/1ps
module shbus_arbiter_bench;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    m_cyc, m_stb, m_lock, m_we;
    logic [N*AW-1:0] m_adr;
    logic [N*DW-1:0] m_wdat;
    logic [DW-1:0]   m_rdat;
    logic [N-1:0]    m_ack, m_err, m_rty, m_gnt;
    logic            s_cyc, s_stb, s_we;
    logic [AW-1:0]   s_adr;
    logic [DW-1:0]   s_wdat;
    logic [DW-1:0]   s_rdat;
    logic            s_ack, s_err, s_rty;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    shbus_arbiter #(.N_MASTERS(N), .AW(AW), .DW(DW)) u_shbus_arbiter (
        .clk(clk), .rst(rst),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_lock(m_lock), .m_we(m_we),
        .m_adr(m_adr), .m_wdat(m_wdat), .m_rdat(m_rdat),
        .m_ack(m_ack), .m_err(m_err), .m_rty(m_rty), .m_gnt(m_gnt),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_wdat(s_wdat), .s_rdat(s_rdat),
        .s_ack(s_ack), .s_err(s_err), .s_rty(s_rty)
    );

    function automatic logic [AW-1:0] adr_of(int i);
        return AW'(16'h1000 + i * 16'h0111);
    endfunction

    function automatic logic [DW-1:0] dat_of(int i);
        return DW'(32'hA5000000 + i * 32'h00010203);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #0.5;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_cyc = '0; m_stb = '0; m_lock = '0;
        s_ack = 1'b0; s_err = 1'b0; s_rty = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(m_gnt == '0, "R1 grant cleared", m_gnt, 0);
        chk(!s_cyc && !s_stb, "R1 slave strobes low", {s_cyc, s_stb}, 0);
        m_cyc = 4'b0001; m_stb = 4'b0001; s_ack = 1'b1; s_err = 1'b1; s_rty = 1'b1;
        settle();
        chk((m_ack | m_err | m_rty) == '0, "R1 no termination without grant", m_ack | m_err | m_rty, 0);
        s_ack = 1'b0; s_err = 1'b0; s_rty = 1'b0;
    endtask

    task automatic t_priority();
        do_reset();
        m_cyc = 4'b1010;
        tick();
        chk(m_gnt == 4'b0010, "R2 lowest index granted", m_gnt, 4'b0010);
        chk(s_adr == adr_of(1), "R3 address routed", s_adr, adr_of(1));
        chk(s_wdat == dat_of(1), "R3 write data routed", s_wdat, dat_of(1));
        chk(s_we == m_we[1], "R3 write enable routed", s_we, m_we[1]);
        chk(s_cyc && !s_stb, "R3 cyc without stb", {s_cyc, s_stb}, 2'b10);
        m_stb = 4'b1010; s_ack = 1'b1; s_rdat = 32'hDEADBEEF;
        settle();
        chk(s_stb == 1'b1, "R3 strobe routed", s_stb, 1);
        chk(m_ack == 4'b0010, "R9 ack only to owner", m_ack, 4'b0010);
        chk(m_rdat == 32'hDEADBEEF, "R3 read data returned", m_rdat, 32'hDEADBEEF);
        s_ack = 1'b0; s_err = 1'b1;
        settle();
        chk(m_err == 4'b0010, "R9 err only to owner", m_err, 4'b0010);
        s_err = 1'b0; s_rty = 1'b1;
        settle();
        chk(m_rty == 4'b0010, "R9 rty only to owner", m_rty, 4'b0010);
        s_rty = 1'b0;
    endtask

    task automatic t_idle_hold();
        do_reset();
        m_cyc = 4'b0100;
        tick();
        chk(m_gnt == 4'b0100, "R2 single requester granted", m_gnt, 4'b0100);
        m_cyc = 4'b1100; m_stb = 4'b1000;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(m_gnt == 4'b0100, "R4 idle owner keeps bus", m_gnt, 4'b0100);
            chk(!s_stb, "R4 no strobe while owner idle", s_stb, 0);
        end
        s_ack = 1'b1;
        settle();
        chk(m_ack == '0, "R9 no ack to idle owner or waiting master", m_ack, 0);
        s_ack = 1'b0;
    endtask

    task automatic t_preempt();
        do_reset();
        m_cyc = 4'b0100;
        tick();
        m_cyc = 4'b0101;
        tick();
        chk(m_gnt == 4'b0001, "R5 unlocked owner preempted", m_gnt, 4'b0001);
        chk(s_adr == adr_of(0), "R5 new owner address routed", s_adr, adr_of(0));
        m_stb = 4'b0100; s_ack = 1'b1;
        settle();
        chk(m_ack == '0, "R9 preempted master sees no ack", m_ack, 0);
        m_stb = 4'b0101;
        settle();
        chk(m_ack == 4'b0001, "R9 new owner receives ack", m_ack, 4'b0001);
        s_ack = 1'b0;
    endtask

    task automatic t_mid_xfer();
        do_reset();
        m_cyc = 4'b0100;
        tick();
        m_stb = 4'b0100; m_cyc = 4'b0101;
        tick();
        chk(m_gnt == 4'b0100, "R8 pending strobe blocks preemption", m_gnt, 4'b0100);
        tick();
        chk(m_gnt == 4'b0100, "R8 still blocked while waiting", m_gnt, 4'b0100);
        s_rty = 1'b1;
        settle();
        chk(m_rty == 4'b0100, "R9 retry to owner mid transfer", m_rty, 4'b0100);
        tick();
        chk(m_gnt == 4'b0001, "R8 termination edge re-arbitrates", m_gnt, 4'b0001);
        s_rty = 1'b0;
    endtask

    task automatic t_lock();
        do_reset();
        m_cyc = 4'b1000; m_lock = 4'b1000;
        tick();
        chk(m_gnt == 4'b1000, "R2 locked master granted", m_gnt, 4'b1000);
        m_cyc = 4'b1001;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(m_gnt == 4'b1000, "R6 lock refuses preemption", m_gnt, 4'b1000);
        end
        m_lock = 4'b0000;
        tick();
        chk(m_gnt == 4'b0001, "R7 lock released by dropping LOCK", m_gnt, 4'b0001);

        do_reset();
        m_cyc = 4'b1000; m_lock = 4'b1000;
        tick();
        m_cyc = 4'b0010;
        tick();
        chk(m_gnt == 4'b0010, "R7 lock released by dropping CYC", m_gnt, 4'b0010);
        m_cyc = 4'b0011;
        tick();
        chk(m_gnt == 4'b0001, "R7 stray LOCK without CYC ignored", m_gnt, 4'b0001);
        m_lock = 4'b0000;
    endtask

    task automatic t_none();
        do_reset();
        m_cyc = 4'b0010; m_stb = 4'b0010;
        tick();
        m_cyc = 4'b0000;
        tick();
        chk(m_gnt == 4'b0010, "R10 last grant held", m_gnt, 4'b0010);
        chk(!s_cyc && !s_stb, "R10 slave strobes low with no request", {s_cyc, s_stb}, 0);
        m_cyc = 4'b1000;
        tick();
        chk(m_gnt == 4'b1000, "R10 new request granted after idle", m_gnt, 4'b1000);
        m_stb = '0;
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        m_cyc = '0; m_stb = '0; m_lock = '0;
        s_ack = 1'b0; s_err = 1'b0; s_rty = 1'b0; s_rdat = '0;
        for (int i = 0; i < N; i++) begin
            m_adr[i*AW +: AW]  = adr_of(i);
            m_wdat[i*DW +: DW] = dat_of(i);
            m_we[i]            = i[0];
        end
        t_reset();
        t_priority();
        t_idle_hold();
        t_preempt();
        t_mid_xfer();
        t_lock();
        t_none();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule